// File: doc/BRIEF.md
# Tape Byte Transfer Sequencer

This block paces the byte stream between a record buffer and the host data channel while a tape read or write is in progress. A command unit starts it with a direction bit. After a start-up delay, a service slot comes up at a fixed per-byte interval. In each slot the block moves one byte, raises the data-channel flag and watches for a host that has fallen behind. Once the data phase is over, the block waits for an inter-record gap and then raises a completion flag.

On a read, the first slot takes in the record length and the file-mark indication from the buffer side. A file mark, or a record too short to be valid, ends the operation without moving any data. On a write, the first slot moves no byte. Each later slot stores the byte the host presented last. The host ends a write by pulsing a stop strobe, and the next slot then commits the filled part of the buffer as a record. One clock cycle is one timing unit.

Top module: `tape_xfer_seq`

## Requirements
- R1: After reset, busy, done_flag, dch_flag, srq, rec_commit, par_err, tim_err and eof are 0, and bot is 1.
- R2: The first service slot comes START_TICKS cycles after the cycle in which start is sampled while idle. Each later data slot follows the one before it by BYTE_TICKS cycles.
- R3: On a read, each data slot places buffer byte number ptr (counting from address 0) on rd_byte and sets dch_flag, until rec_len bytes have been moved. srq always equals dch_flag.
- R4: On a read, tim_err is set when a byte is placed while dch_flag is still set from the previous byte. It stays 0 if the host acknowledged every byte in time.
- R5: On a read, a rec_len below MIN_REC at the first slot sets par_err and completes the operation in that slot. No gap follows, and dch_flag is never raised.
- R6: On a read, rec_mark high at the first slot sets eof. The gap then runs and the operation completes with no byte moved.
- R7: On a write, the first slot stores nothing and only raises dch_flag. Each later slot writes host_wdata to successive buffer addresses starting at 0, and the first stored byte clears bot.
- R8: A write slot that finds 2^ADDR_W bytes already stored sets par_err and writes nothing.
- R9: A stop_xfer pulse ends the data phase at the next slot. On a write, that slot still stores its byte; then, if at least one byte is stored, rec_commit pulses for one cycle with commit_len equal to the byte count. A write with nothing stored commits nothing.
- R10: After the data phase ends, busy stays 1 for GAP_TICKS more cycles. done_flag then rises in the same cycle that busy falls. For a record of N bytes, this is START_TICKS + N*BYTE_TICKS + GAP_TICKS cycles after start.
- R11: dch_ack clears dch_flag on the next edge unless a slot sets the flag in that same cycle.
- R12: A start pulse while busy is ignored: the running operation keeps its direction and timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| start_write | input | 1 | Direction for start: 1 write, 0 read |
| stop_xfer | input | 1 | Host strobe that ends the data phase |
| dch_ack | input | 1 | Host acknowledge, clears dch_flag |
| host_wdata | input | 8 | Byte from the host for writes |
| rec_len | input | ADDR_W+1 | Length of the record to read, sampled at the first slot |
| rec_mark | input | 1 | Record to read is a file mark, sampled at the first slot |
| buf_rdata | input | 8 | Buffer read data at buf_addr (combinational) |
| buf_addr | output | ADDR_W | Buffer address, equal to the byte pointer |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| rd_byte | output | 8 | Last byte read for the host |
| dch_flag | output | 1 | Data-channel byte flag |
| srq | output | 1 | Service request, follows dch_flag |
| busy | output | 1 | Operation in progress |
| done_flag | output | 1 | Operation complete (control flag) |
| rec_commit | output | 1 | One-cycle pulse: the write buffer is a record |
| commit_len | output | ADDR_W+1 | Byte count of the committed record |
| par_err | output | 1 | Short record or buffer overflow |
| tim_err | output | 1 | Host overrun on read |
| eof | output | 1 | File mark seen |
| bot | output | 1 | At beginning of tape, cleared by the first stored byte |

## Verification
The bench measures the exact cycle of the first and second byte flags and of completion for reads, writes, file marks and short records. A miscounted timer or a missing gap shows up as an elapsed-time mismatch. It checks that write data lands at addresses starting at 0 with the first slot skipped: storing in the first slot would shift every byte by one address. It checks that an over-long write stops at the buffer size with par_err and commits the full count. It checks that an empty write commits nothing and leaves bot set. A host that never acknowledges must produce tim_err. A start pulse injected mid-read must not turn the read into a write.

// File: rtl/tape_xfer_seq.sv
module tape_xfer_seq #(
  parameter int ADDR_W      = 6,
  parameter int START_TICKS = 40,
  parameter int BYTE_TICKS  = 15,
  parameter int GAP_TICKS   = 1000,
  parameter int MIN_REC     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic              stop_xfer,
  input  logic              dch_ack,
  input  logic [7:0]        host_wdata,
  input  logic [ADDR_W:0]   rec_len,
  input  logic              rec_mark,
  input  logic [7:0]        buf_rdata,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic [7:0]        rd_byte,
  output logic              dch_flag,
  output logic              srq,
  output logic              busy,
  output logic              done_flag,
  output logic              rec_commit,
  output logic [ADDR_W:0]   commit_len,
  output logic              par_err,
  output logic              tim_err,
  output logic              eof,
  output logic              bot
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(START_TICKS + BYTE_TICKS + GAP_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_GAP} phase_t;

  phase_t        phase;
  logic [TW-1:0] tmr;
  logic          wr_mode, first, dtf;
  logic [PW-1:0] ptr, len;

  wire go        = start && (phase == S_IDLE);
  wire svc       = (phase != S_IDLE) && (tmr == TW'(1));
  wire data_svc  = svc && (phase == S_DATA);
  wire rd_first  = data_svc && !wr_mode && first;
  wire rd_mark   = rd_first && rec_mark;
  wire rd_short  = rd_first && !rec_mark && (rec_len < PW'(MIN_REC));
  wire [PW-1:0] eff_len = first ? rec_len : len;
  wire rd_xfer   = data_svc && !wr_mode && !rd_mark && !rd_short && dtf && (ptr < eff_len);
  wire wr_full   = (ptr == PW'(DEPTH));
  wire wr_try    = data_svc && wr_mode && !first;
  wire flag_set  = rd_xfer || (data_svc && wr_mode && dtf);
  wire [PW-1:0] ptr_n = ptr + PW'(buf_we || rd_xfer);

  assign buf_we    = wr_try && !wr_full;
  assign buf_addr  = ptr[ADDR_W-1:0];
  assign buf_wdata = host_wdata;
  assign srq       = dch_flag;
  assign busy      = (phase != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= S_IDLE;
      tmr        <= '0;
      wr_mode    <= 1'b0;
      first      <= 1'b0;
      dtf        <= 1'b0;
      ptr        <= '0;
      len        <= '0;
      rd_byte    <= '0;
      dch_flag   <= 1'b0;
      done_flag  <= 1'b0;
      rec_commit <= 1'b0;
      commit_len <= '0;
      par_err    <= 1'b0;
      tim_err    <= 1'b0;
      eof        <= 1'b0;
      bot        <= 1'b1;
    end else begin
      rec_commit <= 1'b0;
      if (flag_set)     dch_flag <= 1'b1;
      else if (dch_ack) dch_flag <= 1'b0;
      if (stop_xfer) dtf <= 1'b0;
      if (go) begin
        phase     <= S_DATA;
        tmr       <= TW'(START_TICKS);
        wr_mode   <= start_write;
        first     <= 1'b1;
        dtf       <= 1'b1;
        ptr       <= '0;
        dch_flag  <= 1'b0;
        done_flag <= 1'b0;
        par_err   <= 1'b0;
        tim_err   <= 1'b0;
        eof       <= 1'b0;
      end else if (phase != S_IDLE) begin
        if (!svc) begin
          tmr <= tmr - TW'(1);
        end else if (phase == S_GAP) begin
          phase     <= S_IDLE;
          done_flag <= 1'b1;
        end else begin
          first <= 1'b0;
          ptr   <= ptr_n;
          if (first) len <= rec_len;
          if (wr_mode) begin
            if (!first) begin
              if (wr_full) par_err <= 1'b1;
              else         bot     <= 1'b0;
            end
            if (dtf) begin
              tmr <= TW'(BYTE_TICKS);
            end else begin
              if (ptr_n != '0) begin
                rec_commit <= 1'b1;
                commit_len <= ptr_n;
              end
              phase <= S_GAP;
              tmr   <= TW'(GAP_TICKS);
            end
          end else if (rd_short) begin
            par_err   <= 1'b1;
            phase     <= S_IDLE;
            done_flag <= 1'b1;
          end else if (rd_xfer) begin
            rd_byte <= buf_rdata;
            if (dch_flag) tim_err <= 1'b1;
            tmr <= TW'(BYTE_TICKS);
          end else begin
            if (rd_mark) eof <= 1'b1;
            phase <= S_GAP;
            tmr   <= TW'(GAP_TICKS);
          end
        end
      end
    end
  end

  // R11
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dch_ack && !flag_set && !go) |=> !dch_flag);

  // R10
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (ptr < PW'(DEPTH)));

  // R7
  first_slot_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !buf_we);

  // R4
  tim_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tim_err) |-> (busy && !wr_mode));

  // R12
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(wr_mode));
endmodule

// File: tb/tape_xfer_seq_bench.sv
module tape_xfer_seq_bench;
  localparam int AW = 6;
  localparam int ST = 40, BT = 15, GT = 1000;

  logic clk = 0, rst_n = 0;
  logic start = 0, start_write = 0, stop_xfer = 0, dch_ack = 0, rec_mark = 0;
  logic [7:0] host_wdata = 0;
  logic [AW:0] rec_len = 0;
  logic [7:0] buf_rdata;
  logic [AW-1:0] buf_addr;
  logic buf_we;
  logic [7:0] buf_wdata, rd_byte;
  logic dch_flag, srq, busy, done_flag, rec_commit, par_err, tim_err, eof, bot;
  logic [AW:0] commit_len;

  tape_xfer_seq #(.ADDR_W(AW), .START_TICKS(ST), .BYTE_TICKS(BT), .GAP_TICKS(GT), .MIN_REC(12))
  u_tape_xfer_seq (.*);

  always #2 clk = ~clk;

  logic [7:0] mem [64];
  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int commits = 0;
  int last_len = 0;
  always @(posedge clk) if (rec_commit) begin commits <= commits + 1; last_len <= int'(commit_len); end

  int errors = 0, checks = 0;
  int t0, nflags, elapsed, t_first, t_second;
  logic [7:0] rbuf [70];
  bit ack_checked;

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(bit wr);
    @(negedge clk); start = 1; start_write = wr;
    @(negedge clk); start = 0; t0 = cyc;
  endtask

  task automatic host(int stop_at, bit ack_en, bit inject, bit wr);
    int guard = 0;
    bit prev = 0;
    nflags = 0; t_first = -1; t_second = -1;
    while (!done_flag && guard < 6000) begin
      if (dch_flag && !prev) begin
        nflags++;
        if (nflags == 1) t_first = cyc - t0;
        if (nflags == 2) t_second = cyc - t0;
        if (nflags <= 70) rbuf[nflags-1] = rd_byte;
        if (!ack_checked) begin
          chk("R3 srq follows flag", srq == dch_flag, srq, dch_flag);
        end
        if (wr) host_wdata = 8'((nflags * 7 + 3) & 255);
        if (ack_en) dch_ack = 1;
        if (nflags == stop_at) stop_xfer = 1;
        if (inject && nflags == 5) begin start = 1; start_write = !wr; end
        @(negedge clk); guard++;
        dch_ack = 0; stop_xfer = 0; start = 0;
        if (ack_en && !ack_checked) begin
          ack_checked = 1;
          chk("R11 ack clears flag", dch_flag == 0, dch_flag, 0);
        end
        prev = ack_en ? 1'b0 : dch_flag;
      end else begin
        prev = dch_flag;
        @(negedge clk); guard++;
      end
    end
    elapsed = cyc - t0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy == 0, busy, 0);
    chk("R1 done", done_flag == 0, done_flag, 0);
    chk("R1 flag", dch_flag == 0 && srq == 0, dch_flag, 0);
    chk("R1 status", {par_err, tim_err, eof, rec_commit} == 0, {par_err, tim_err, eof, rec_commit}, 0);
    chk("R1 bot", bot == 1, bot, 1);
  endtask

  task automatic t_read;
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 13 + 5) & 255);
    rec_len = 20; rec_mark = 0; ack_checked = 0;
    do_start(0);
    host(0, 1, 1, 0);
    chk("R2 first slot", t_first == ST, t_first, ST);
    chk("R2 byte interval", t_second == ST + BT, t_second, ST + BT);
    chk("R3 byte count", nflags == 20, nflags, 20);
    for (int i = 0; i < 20; i++)
      chk("R3 byte value", rbuf[i] == mem[i], rbuf[i], mem[i]);
    chk("R10 read done time", elapsed == ST + 20 * BT + GT, elapsed, ST + 20 * BT + GT);
    chk("R4 no timing error", tim_err == 0, tim_err, 0);
    chk("R12 no write during read", commits == 0 && mem[0] == 8'd5, commits, 0);
    chk("R10 busy off", busy == 0, busy, 0);
  endtask

  task automatic t_timing;
    rec_len = 14;
    do_start(0);
    host(0, 0, 0, 0);
    chk("R4 timing error", tim_err == 1, tim_err, 1);
    chk("R3 srq held", srq == 1, srq, 1);
    chk("R10 timing read done", elapsed == ST + 14 * BT + GT, elapsed, ST + 14 * BT + GT);
    @(negedge clk); dch_ack = 1; @(negedge clk); dch_ack = 0;
  endtask

  task automatic t_short;
    rec_len = 11;
    do_start(0);
    host(0, 1, 0, 0);
    chk("R5 short par", par_err == 1, par_err, 1);
    chk("R5 short no data", nflags == 0, nflags, 0);
    chk("R5 short done time", elapsed == ST, elapsed, ST);
  endtask

  task automatic t_mark;
    rec_len = 30; rec_mark = 1;
    do_start(0);
    host(0, 1, 0, 0);
    rec_mark = 0;
    chk("R6 eof", eof == 1, eof, 1);
    chk("R6 no data", nflags == 0, nflags, 0);
    chk("R6 gap time", elapsed == ST + GT, elapsed, ST + GT);
    chk("R6 par clear", par_err == 0, par_err, 0);
  endtask

  task automatic t_empty_write;
    commits = 0;
    @(negedge clk); start = 1; start_write = 1;
    @(negedge clk); start = 0; t0 = cyc; stop_xfer = 1;
    @(negedge clk); stop_xfer = 0;
    host(0, 1, 0, 1);
    chk("R9 empty no commit", commits == 0, commits, 0);
    chk("R9 empty done time", elapsed == ST + GT, elapsed, ST + GT);
    chk("R7 bot kept", bot == 1, bot, 1);
  endtask

  task automatic t_write;
    for (int i = 0; i < 64; i++) mem[i] = 8'hEE;
    commits = 0;
    do_start(1);
    host(10, 1, 0, 1);
    chk("R2 write first slot", t_first == ST, t_first, ST);
    chk("R9 commit count", commits == 1, commits, 1);
    chk("R9 commit len", last_len == 10, last_len, 10);
    for (int i = 0; i < 10; i++)
      chk("R7 stored byte", mem[i] == 8'(((i + 1) * 7 + 3) & 255), mem[i], ((i + 1) * 7 + 3) & 255);
    chk("R7 no extra store", mem[10] == 8'hEE, mem[10], 8'hEE);
    chk("R7 bot cleared", bot == 0, bot, 0);
    chk("R10 write done time", elapsed == ST + 10 * BT + GT, elapsed, ST + 10 * BT + GT);
    chk("R8 no par", par_err == 0, par_err, 0);
  endtask

  task automatic t_full;
    commits = 0;
    do_start(1);
    host(66, 1, 0, 1);
    chk("R8 overflow par", par_err == 1, par_err, 1);
    chk("R8 commit len full", last_len == 64, last_len, 64);
    chk("R8 last stored", mem[63] == 8'((64 * 7 + 3) & 255), mem[63], (64 * 7 + 3) & 255);
    chk("R8 first kept", mem[0] == 8'(10), mem[0], 10);
    chk("R10 full done time", elapsed == ST + 66 * BT + GT, elapsed, ST + 66 * BT + GT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_timing();
    t_short();
    t_mark();
    t_empty_write();
    t_write();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule